// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block sits in front of the paged translation unit and classifies each memory access in the cycle it is accepted. When translation is switched off, the access goes straight through. The physical address is then the virtual address, and the access carries full permission. When translation is on and a kernel access falls in a segment that the segment bitmap marks, the block applies a fixed 256 MB window. The top nibble of the physical address comes from one of two packed kernel-base words, and the low 28 bits are copied from the virtual address. Every other access becomes a request to the page lookup, which is outside this block. The request carries the address, the access type and the user flag.

Requests use a valid/ready handshake. A bypassed or segment-mapped access gives a registered result one cycle after acceptance. A page-lookup request keeps the block busy until the lookup reports done. The block then returns that lookup's address and hit status unchanged. Each request and each result also carries a select between the instruction MMU and the data MMU.

Top module: `segx_front`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, and `rsp_valid` and `pl_valid` are 0.
- R2: When `xl_mode` is 0, an accepted access produces `rsp_valid` on the next cycle with `rsp_paddr` equal to the virtual address, `rsp_full_perm` = 1 and `rsp_fault` = 0. No page-lookup request is made.
- R3: When translation is on, an accepted kernel access (`req_user` = 0) whose segment `req_vaddr[31:28]` has its bit set in `seg_map` gives a result on the next cycle. In that result `rsp_paddr[31:28]` is the base nibble, `rsp_paddr[27:0]` equals `req_vaddr[27:0]`, `rsp_full_perm` = 1 and `rsp_fault` = 0.
- R4: For segment s, the base nibble is `kbase_lo[4*(s%8)+3 : 4*(s%8)]` when s < 8 and `kbase_hi[4*(s%8)+3 : 4*(s%8)]` when s >= 8.
- R5: A user access (`req_user` = 1) is never segment-mapped. With translation on, it always becomes a page-lookup request, even when its segment bit is set.
- R6: With translation on, an access that is not segment-mapped raises `pl_valid` on the cycle after acceptance, with `pl_vaddr`, `pl_acc` and `pl_user` equal to the request. `pl_valid` and these fields hold, and `req_ready` stays 0, until `pl_done`.
- R7: Access code 2 (execute) selects the instruction MMU (`*_imu` = 1). Codes 0 (read), 1 (write) and 3 (treated as read) select the data MMU (`*_imu` = 0). This applies to both `pl_imu` and `rsp_imu`.
- R8: When `pl_done` is sampled while a lookup is pending, the next cycle carries `rsp_valid` with `rsp_paddr` = `pl_paddr`, `rsp_fault` = NOT `pl_hit` and `rsp_full_perm` = 0. `req_ready` returns to 1.
- R9: `pl_done` while no lookup is pending is ignored: no `rsp_valid` follows.
- R10: Translation is on when either bit of the 2-bit `xl_mode` field is set. `xl_mode` = 1 and `xl_mode` = 2 each enable segment mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | 1 for a user-mode access |
| xl_mode | input | 2 | Translation enable field of the global configuration |
| seg_map | input | 16 | Per-segment kernel mapping bitmap |
| kbase_lo | input | 32 | Packed base nibbles for segments 0..7 |
| kbase_hi | input | 32 | Packed base nibbles for segments 8..15 |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_full_perm | output | 1 | All permissions granted |
| rsp_fault | output | 1 | Page lookup reported a miss or fault |
| rsp_imu | output | 1 | Result belongs to the instruction MMU |
| pl_valid | output | 1 | Page lookup request pending |
| pl_vaddr | output | 32 | Lookup virtual address |
| pl_acc | output | 2 | Lookup access type |
| pl_user | output | 1 | Lookup user flag |
| pl_imu | output | 1 | Lookup targets the instruction MMU |
| pl_done | input | 1 | Lookup finished |
| pl_hit | input | 1 | Lookup found a usable entry |
| pl_paddr | input | 32 | Lookup physical address |

## Verification
The bench targets the nibble selection at the edges of both base words: segments 0, 3, 7, 8, 12 and 15. A design with a wrong shift or a swapped low/high choice would return the wrong top nibble. It drives user accesses into mapped segments, where a design that ignored the user flag would answer in one cycle instead of issuing a lookup. It enables translation with each mode bit alone, which catches a design that tests only one bit. It also drives stray lookup-done pulses and lookup faults. A design that answered with no lookup pending would produce an unexpected result, and one that inverted or dropped the hit flag would report the wrong fault.

// File: rtl/segx_pkg.sv
// Shared encodings for the segment address translator.
// Assumes access codes fixed by the requesting pipeline.
package segx_pkg;

    // Access type carried on every request
    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    // Which path an accepted access takes
    typedef enum logic [1:0] {
        PATH_FLAT = 2'd0,
        PATH_SEG  = 2'd1,
        PATH_PAGE = 2'd2
    } path_e;

endpackage

// File: rtl/segx_base_pick.sv
// Selects the base nibble of a segment from two packed base words.
// Assumes segments in the lower half use the low word, the rest the high one.
module segx_base_pick #(
    parameter int SEG_W = 4,
    localparam int NSEG = 1 << SEG_W,
    localparam int HALF = NSEG / 2,
    localparam int KB_W = HALF * SEG_W
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [KB_W-1:0]  kbase_lo,
    input  logic [KB_W-1:0]  kbase_hi,
    output logic [SEG_W-1:0] nib
);
    logic [SEG_W-1:0] lo_nib [HALF];
    logic [SEG_W-1:0] hi_nib [HALF];

    // Unpack both base words into nibble arrays
    for (genvar g = 0; g < HALF; g++) begin : g_unpack
        assign lo_nib[g] = kbase_lo[g*SEG_W +: SEG_W];
        assign hi_nib[g] = kbase_hi[g*SEG_W +: SEG_W];
    end

    // Pick the word by the segment MSB and the nibble by the rest
    always_comb begin
        if (seg[SEG_W-1]) nib = hi_nib[seg[SEG_W-2:0]];
        else              nib = lo_nib[seg[SEG_W-2:0]];
    end
endmodule

// File: rtl/segx_classify.sv
// Combinational classification of one access: flat, segment or paged.
// Assumes configuration inputs are stable while the request is presented.
module segx_classify
    import segx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 4,
    localparam int NSEG  = 1 << SEG_W,
    localparam int KB_W  = (NSEG / 2) * SEG_W,
    localparam int OFS_W = ADDR_W - SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        acc,
    input  logic              user,
    input  logic              xl_on,
    input  logic [NSEG-1:0]   seg_map,
    input  logic [KB_W-1:0]   kbase_lo,
    input  logic [KB_W-1:0]   kbase_hi,
    output path_e             path,
    output logic [ADDR_W-1:0] paddr,
    output logic              imu
);
    logic [SEG_W-1:0] seg;
    logic [SEG_W-1:0] nib;
    logic             seg_hit;

    assign seg     = vaddr[ADDR_W-1 -: SEG_W];
    assign seg_hit = !user && seg_map[seg];
    assign imu     = (acc == ACC_EX);

    segx_base_pick #(.SEG_W(SEG_W)) u_pick (
        .seg      (seg),
        .kbase_lo (kbase_lo),
        .kbase_hi (kbase_hi),
        .nib      (nib)
    );

    // Choose the path and the address it would produce
    always_comb begin
        if (!xl_on) begin
            path  = PATH_FLAT;
            paddr = vaddr;
        end else if (seg_hit) begin
            path  = PATH_SEG;
            paddr = {nib, vaddr[OFS_W-1:0]};
        end else begin
            path  = PATH_PAGE;
            paddr = vaddr;
        end
    end

    // R5: user accesses under translation always go to the page lookup
    assert_user_paged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_on && user) |-> (path == PATH_PAGE));
endmodule

// File: rtl/segx_ctrl.sv
// Handshake, busy tracking and output registers of the translator.
// Assumes the lookup holds pl_done for one cycle per request.
module segx_ctrl
    import segx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  path_e             path,
    input  logic [ADDR_W-1:0] cls_paddr,
    input  logic              cls_imu,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_full_perm,
    output logic              rsp_fault,
    output logic              rsp_imu,
    output logic              pl_valid,
    output logic [ADDR_W-1:0] pl_vaddr,
    output logic [1:0]        pl_acc,
    output logic              pl_user,
    output logic              pl_imu,
    input  logic              pl_done,
    input  logic              pl_hit,
    input  logic [ADDR_W-1:0] pl_paddr
);
    typedef enum logic {ST_IDLE, ST_BUSY} st_e;
    st_e state;

    assign req_ready = (state == ST_IDLE);

    // Accept requests, issue lookups and register results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_full_perm <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_imu       <= 1'b0;
            pl_valid      <= 1'b0;
            pl_vaddr      <= '0;
            pl_acc        <= '0;
            pl_user       <= 1'b0;
            pl_imu        <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (path == PATH_PAGE) begin
                            state    <= ST_BUSY;
                            pl_valid <= 1'b1;
                            pl_vaddr <= req_vaddr;
                            pl_acc   <= req_acc;
                            pl_user  <= req_user;
                            pl_imu   <= cls_imu;
                        end else begin
                            rsp_valid     <= 1'b1;
                            rsp_paddr     <= cls_paddr;
                            rsp_full_perm <= 1'b1;
                            rsp_fault     <= 1'b0;
                            rsp_imu       <= cls_imu;
                        end
                    end
                end
                default: begin
                    if (pl_done) begin
                        state         <= ST_IDLE;
                        pl_valid      <= 1'b0;
                        rsp_valid     <= 1'b1;
                        rsp_paddr     <= pl_paddr;
                        rsp_full_perm <= 1'b0;
                        rsp_fault     <= !pl_hit;
                        rsp_imu       <= pl_imu;
                    end
                end
            endcase
        end
    end

    // R2: flat and segment accesses answer on the next cycle with full permission
    assert_fast_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && path != PATH_PAGE) |=> (rsp_valid && rsp_full_perm && !rsp_fault));

    // R6: no new request is accepted while a lookup is pending
    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> !req_ready);

    // R6: a pending lookup request holds its fields until done
    assert_pl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_done) |=> (pl_valid && $stable(pl_vaddr) && $stable(pl_acc) && $stable(pl_user)));

    // R7: lookup routing follows the access type
    assert_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> (pl_imu == (pl_acc == 2'(ACC_EX))));

    // R8: a finished lookup is passed through unchanged
    assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_done) |=> (rsp_valid && rsp_paddr == $past(pl_paddr) && rsp_fault == !$past(pl_hit)));

    // R9: a result only follows an accepted request or a finished lookup
    assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && req_ready) && !(pl_valid && pl_done)) |=> !rsp_valid);
endmodule

// File: rtl/segx_front.sv
// Front end of the MMU: bypass, kernel segment window, or page lookup request.
// Assumes the lookup returns exactly one done pulse per issued request.
module segx_front
    import segx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 4,
    parameter int MODE_W = 2,
    localparam int NSEG  = 1 << SEG_W,
    localparam int KB_W  = (NSEG / 2) * SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic [MODE_W-1:0] xl_mode,
    input  logic [NSEG-1:0]   seg_map,
    input  logic [KB_W-1:0]   kbase_lo,
    input  logic [KB_W-1:0]   kbase_hi,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_full_perm,
    output logic              rsp_fault,
    output logic              rsp_imu,
    output logic              pl_valid,
    output logic [ADDR_W-1:0] pl_vaddr,
    output logic [1:0]        pl_acc,
    output logic              pl_user,
    output logic              pl_imu,
    input  logic              pl_done,
    input  logic              pl_hit,
    input  logic [ADDR_W-1:0] pl_paddr
);
    path_e             path;
    logic [ADDR_W-1:0] cls_paddr;
    logic              cls_imu;
    logic              xl_on;

    assign xl_on = |xl_mode;

    segx_classify #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .vaddr    (req_vaddr),
        .acc      (req_acc),
        .user     (req_user),
        .xl_on    (xl_on),
        .seg_map  (seg_map),
        .kbase_lo (kbase_lo),
        .kbase_hi (kbase_hi),
        .path     (path),
        .paddr    (cls_paddr),
        .imu      (cls_imu)
    );

    segx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .req_user      (req_user),
        .path          (path),
        .cls_paddr     (cls_paddr),
        .cls_imu       (cls_imu),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_full_perm (rsp_full_perm),
        .rsp_fault     (rsp_fault),
        .rsp_imu       (rsp_imu),
        .pl_valid      (pl_valid),
        .pl_vaddr      (pl_vaddr),
        .pl_acc        (pl_acc),
        .pl_user       (pl_user),
        .pl_imu        (pl_imu),
        .pl_done       (pl_done),
        .pl_hit        (pl_hit),
        .pl_paddr      (pl_paddr)
    );
endmodule

// File: tb/test_segx_front.sv
module test_segx_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_user;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic [1:0]  xl_mode;
    logic [15:0] seg_map;
    logic [31:0] kbase_lo, kbase_hi;
    logic        rsp_valid, rsp_full_perm, rsp_fault, rsp_imu;
    logic [31:0] rsp_paddr;
    logic        pl_valid, pl_user, pl_imu;
    logic [31:0] pl_vaddr;
    logic [1:0]  pl_acc;
    logic        pl_done, pl_hit;
    logic [31:0] pl_paddr;

    int checks = 0;
    int errors = 0;
    logic [34:0] expq [$];
    string       tagq [$];

    always #4 clk = ~clk;

    segx_front i_segx_front (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
        .xl_mode(xl_mode), .seg_map(seg_map), .kbase_lo(kbase_lo), .kbase_hi(kbase_hi),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_full_perm(rsp_full_perm),
        .rsp_fault(rsp_fault), .rsp_imu(rsp_imu), .pl_valid(pl_valid),
        .pl_vaddr(pl_vaddr), .pl_acc(pl_acc), .pl_user(pl_user), .pl_imu(pl_imu),
        .pl_done(pl_done), .pl_hit(pl_hit), .pl_paddr(pl_paddr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result {paddr, full_perm, fault, imu} from the requirements
    function automatic logic [34:0] model(input logic [31:0] va, input logic [1:0] acc,
                                          input logic user, output bit paged);
        logic [3:0]  seg;
        logic [31:0] base;
        logic [3:0]  nib;
        logic        im;
        seg   = va[31:28];
        im    = (acc == 2'd2);
        paged = 1'b0;
        if (xl_mode == 2'd0) return {va, 1'b1, 1'b0, im};
        if (!user && seg_map[seg]) begin
            base = (seg < 4'd8) ? kbase_lo : kbase_hi;
            nib  = 4'((base >> (4 * (seg % 8))) & 32'hF);
            return {nib, va[27:0], 1'b1, 1'b0, im};
        end
        paged = 1'b1;
        return '0;
    endfunction

    // Driver: issues one access, plays the page lookup when needed
    task automatic access(input logic [31:0] va, input logic [1:0] acc, input logic user,
                          input string tag, input logic hit, input logic [31:0] tpa, input int dly);
        bit          paged;
        logic [34:0] e;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_user = user; req_valid = 1'b1;
        e = model(va, acc, user, paged);
        while (!req_ready) @(negedge clk);
        if (!paged) begin
            expq.push_back(e); tagq.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (paged) begin
            check(pl_valid && pl_vaddr == va && pl_acc == acc && pl_user == user,
                  {tag, " R6 lookup request"}, {pl_valid, pl_user, pl_acc, pl_vaddr},
                  {1'b1, user, acc, va});
            check(pl_imu == (acc == 2'd2), {tag, " R7 lookup route"}, 64'(pl_imu), 64'(acc == 2'd2));
            for (int i = 0; i < dly; i++) begin
                check(!req_ready && pl_valid && pl_vaddr == va, "R6 busy hold",
                      {req_ready, pl_valid}, 64'b01);
                @(negedge clk);
            end
            pl_done = 1'b1; pl_hit = hit; pl_paddr = tpa;
            expq.push_back({tpa, 1'b0, !hit, acc == 2'd2}); tagq.push_back({tag, " R8"});
            @(negedge clk);
            pl_done = 1'b0;
        end
    endtask

    // Monitor: compares each result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected result", 64'(rsp_paddr), 64'h0);
            end else begin
                logic [34:0] e;
                string       t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({rsp_paddr, rsp_full_perm, rsp_fault, rsp_imu} == e, t,
                      64'({rsp_paddr, rsp_full_perm, rsp_fault, rsp_imu}), 64'(e));
            end
        end
    end

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_user = 1'b0;
        xl_mode = '0; seg_map = '0; kbase_lo = 32'h0123_4567; kbase_hi = 32'h89AB_CDEF;
        pl_done = 1'b0; pl_hit = 1'b0; pl_paddr = '0;
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !pl_valid, "R1 reset state",
              {req_ready, rsp_valid, pl_valid}, 64'b100);
        rst_n = 1'b1;

        // R2: translation off, identity with full permission; R7 route
        seg_map = 16'hFFFF;
        access(32'hDEAD_BEEF, 2'd0, 1'b0, "R2 flat read", 1'b0, '0, 0);
        access(32'hC000_1234, 2'd2, 1'b1, "R2 R7 flat exec", 1'b0, '0, 0);

        // R3/R4: kernel segment windows across both base words, R10 mode bit 0
        xl_mode = 2'd1; seg_map = 16'b1001_0001_1000_1001;
        access(32'hC123_4567, 2'd0, 1'b0, "R3 R4 seg12", 1'b0, '0, 0);
        access(32'h3ABC_DEF0, 2'd1, 1'b0, "R3 R4 seg3", 1'b0, '0, 0);
        access(32'h0FFF_FFFF, 2'd2, 1'b0, "R4 R7 seg0", 1'b0, '0, 0);
        access(32'h7000_0001, 2'd3, 1'b0, "R4 R7 seg7", 1'b0, '0, 0);
        access(32'h8765_4321, 2'd0, 1'b0, "R4 seg8", 1'b0, '0, 0);
        access(32'hF000_0ABC, 2'd0, 1'b0, "R4 seg15", 1'b0, '0, 0);
        // R10: mode bit 1 alone also enables mapping
        xl_mode = 2'd2;
        access(32'hC0FF_EE00, 2'd0, 1'b0, "R10 mode2 seg12", 1'b0, '0, 0);

        // R5: user access in a mapped segment goes to lookup
        access(32'hC123_4567, 2'd0, 1'b1, "R5 user mapped", 1'b1, 32'h1111_2000, 2);
        // R6/R7/R8: unmapped kernel accesses
        access(32'h5000_4000, 2'd1, 1'b0, "R6 write unmapped", 1'b1, 32'h2222_4000, 3);
        access(32'h6000_8000, 2'd2, 1'b0, "R7 exec unmapped", 1'b0, 32'h3333_8000, 0);
        access(32'h1234_5678, 2'd3, 1'b1, "R7 code3 user", 1'b0, 32'h4444_0000, 1);

        // R9: stray done while idle produces nothing
        @(negedge clk);
        pl_done = 1'b1; pl_hit = 1'b1; pl_paddr = 32'h5555_5555;
        @(negedge clk);
        pl_done = 1'b0;
        check(!rsp_valid && req_ready, "R9 stray done ignored", {rsp_valid, req_ready}, 64'b01);

        access(32'hF123_0000, 2'd0, 1'b0, "R3 after stray", 1'b0, '0, 0);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R8 all results returned", 64'(expq.size()), 64'h0);
        finish_run();
    end
endmodule